// File: doc/BRIEF.md
# Delay-Line Phase Edge Encoder

This block turns the bit pattern left behind by a clock wave running down a tapped delay line into a signed fine-time bin number. A hit freezes every tap at once, and the result is a snapshot. Tap 0 is the tap closest to where the clock enters the line. The snapshot usually holds a stretch of zeros, a stretch of ones and then zeros again. Only the transition nearest tap 0 carries the phase. The encoder finds that transition and reports its position, and the sign of the result gives its direction. A rising step (0 below, 1 above) gives a positive number. A falling step gives a negative number.

A coarse timestamp is captured with the same hit, taken from a free-running clock counter. It travels through the pipeline next to the bin without being changed, so that later stages can combine coarse and fine time. The search is split over two register stages. The input snapshot is registered first. Then the edge search and the sign encoding run in one combinational level and feed the output register. A snapshot with no transition at all produces a zero code and raises an error flag.

Top module: `phaseEdgeEncoder`

## Requirements
- R1: While reset is held and after it is released, `binValid`, `binCode`, `noEdge` and `coarseOut` are all zero until the first result is published.
- R2: `binValid` is high in exactly the cycle two clock edges after the edge that samples `hitValid` high, and is low in every other cycle.
- R3: If the lowest tap index n (1 ≤ n ≤ TAPS-1) at which `phaseSnap[n]` differs from `phaseSnap[n-1]` has `phaseSnap[n-1]`=0 and `phaseSnap[n]`=1, then `binCode` is +n.
- R4: If that first differing position n has `phaseSnap[n-1]`=1 and `phaseSnap[n]`=0, then `binCode` is −n, in two's complement.
- R5: Transitions above the first differing position have no effect on `binCode`, even when the snapshot holds two or more edges.
- R6: A snapshot whose taps are all 0 or all 1 gives `binCode` = 0 with `noEdge` = 1. Any snapshot that has a transition gives `noEdge` = 0.
- R7: `coarseOut` published with a result equals the `coarseIn` value sampled together with that result's `hitValid`.
- R8: In cycles where `binValid` is low, `binCode`, `noEdge` and `coarseOut` keep the values of the last published result. `phaseSnap` and `coarseIn` are ignored while `hitValid` is low.
- R9: Snapshots may arrive on every clock. Each one yields its own result, in arrival order, with the latency given in R2.
- R10: The extreme positions are encoded correctly: ±1 for a step between taps 0 and 1, and ±(TAPS−1) for a step between the last two taps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hitValid | input | 1 | Marks a snapshot and timestamp to encode |
| phaseSnap | input | TAPS | Latched delay-line taps, tap 0 nearest the line input |
| coarseIn | input | COARSE_W | Coarse clock-count timestamp of the hit |
| binValid | output | 1 | Result strobe |
| binCode | output | BIN_W (signed) | Signed fine-time bin, 0 when no edge is found |
| noEdge | output | 1 | Snapshot held no transition |
| coarseOut | output | COARSE_W | Coarse timestamp belonging to the result |

## Verification
Every result is due exactly two clock edges after the edge that samples its `hitValid`. The bench drives each vector on a falling edge and compares the outputs on the falling edge two cycles later, against a model that runs a linear tap scan. It keeps a two-deep history of what it has driven. For an idle slot it expects `binValid` low and the previously published code, flag and timestamp. For a valid slot it expects that vector's bin, flag and coarse value, so a result that arrives one cycle early or late shows up as a miscompare.

// File: rtl/edgeEncPkg.sv
package edgeEncPkg;

  // Strobes from control to datapath, one per register stage
  typedef struct packed {
    logic capture;  // load the input stage
    logic publish;  // load the output stage
  } stageStrobe_t;

endpackage

// File: rtl/edgeEncCtrl.sv
module edgeEncCtrl
  import edgeEncPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);

  logic stage1Valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
    end
  end

  always_comb begin
    strobe.capture = inValid;
    strobe.publish = stage1Valid;
  end

  // R2: a sampled hit is published exactly two edges later
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##2 outValid);

  // R2: no publish without a hit two edges earlier
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !inValid |-> ##2 !outValid);

endmodule

// File: rtl/edgeFinder.sv
module edgeFinder #(
  parameter int TAPS  = 60,
  parameter int IDX_W = $clog2(TAPS)
) (
  input  logic [TAPS-1:0]  snap,
  output logic             found,
  output logic             rising,
  output logic [IDX_W-1:0] pos
);

  logic [TAPS-1:1] diff;   // tap i differs from tap i-1
  logic [TAPS-1:1] seen;   // some lower position already differs
  logic [TAPS-1:1] first;  // one-hot: lowest differing position

  for (genvar i = 1; i < TAPS; i++) begin : gPos
    assign diff[i] = snap[i] ^ snap[i-1];
    if (i == 1) begin : gBase
      assign seen[i] = 1'b0;
    end else begin : gChain
      assign seen[i] = seen[i-1] | diff[i-1];
    end
    assign first[i] = diff[i] & ~seen[i];
  end

  always_comb begin
    pos = '0;
    for (int i = 1; i < TAPS; i++) begin
      if (first[i]) pos = pos | IDX_W'(i);
    end
  end

  assign found  = |diff;
  // the tap above a rising step reads 1
  assign rising = |(first & snap[TAPS-1:1]);

endmodule

// File: rtl/edgeEncDatapath.sv
module edgeEncDatapath
  import edgeEncPkg::*;
#(
  parameter int TAPS     = 60,
  parameter int COARSE_W = 32,
  parameter int IDX_W    = $clog2(TAPS),
  parameter int BIN_W    = IDX_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  stageStrobe_t            strobe,
  input  logic                    outValid,
  input  logic [TAPS-1:0]         snapIn,
  input  logic [COARSE_W-1:0]     coarseIn,
  output logic signed [BIN_W-1:0] binCode,
  output logic                    noEdge,
  output logic [COARSE_W-1:0]     coarseOut
);

  logic [TAPS-1:0]         capSnap;
  logic [COARSE_W-1:0]     capCoarse;
  logic                    found;
  logic                    rising;
  logic [IDX_W-1:0]        pos;
  logic signed [BIN_W-1:0] magnitude;
  logic signed [BIN_W-1:0] nextCode;

  // input stage
  always_ff @(posedge clk) begin
    if (rst) begin
      capSnap   <= '0;
      capCoarse <= '0;
    end else if (strobe.capture) begin
      capSnap   <= snapIn;
      capCoarse <= coarseIn;
    end
  end

  edgeFinder #(.TAPS(TAPS), .IDX_W(IDX_W)) uFinder (
    .snap   (capSnap),
    .found  (found),
    .rising (rising),
    .pos    (pos)
  );

  always_comb begin
    magnitude = signed'({1'b0, pos});
    if (!found)      nextCode = '0;
    else if (rising) nextCode = magnitude;
    else             nextCode = -magnitude;
  end

  // output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      binCode   <= '0;
      noEdge    <= 1'b0;
      coarseOut <= '0;
    end else if (strobe.publish) begin
      binCode   <= nextCode;
      noEdge    <= ~found;
      coarseOut <= capCoarse;
    end
  end

  // R6: the error flag and a zero code always go together in a result
  a_r6_noedge_zero: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (noEdge == (binCode == '0)));

  // R10: a published magnitude never exceeds the last inter-tap position
  a_r10_range: assert property (@(posedge clk) disable iff (rst)
    (outValid && !noEdge) |->
      ((binCode <= BIN_W'(TAPS-1)) && (binCode >= -BIN_W'(TAPS-1))));

  // R8: results hold while no new one is published
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> ($stable(binCode) && $stable(noEdge) && $stable(coarseOut)));

endmodule

// File: rtl/phaseEdgeEncoder.sv
module phaseEdgeEncoder
  import edgeEncPkg::*;
#(
  parameter int TAPS     = 60,
  parameter int COARSE_W = 32,
  parameter int IDX_W    = $clog2(TAPS),
  parameter int BIN_W    = IDX_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hitValid,
  input  logic [TAPS-1:0]         phaseSnap,
  input  logic [COARSE_W-1:0]     coarseIn,
  output logic                    binValid,
  output logic signed [BIN_W-1:0] binCode,
  output logic                    noEdge,
  output logic [COARSE_W-1:0]     coarseOut
);

  stageStrobe_t strobe;

  edgeEncCtrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (hitValid),
    .strobe   (strobe),
    .outValid (binValid)
  );

  edgeEncDatapath #(
    .TAPS(TAPS), .COARSE_W(COARSE_W), .IDX_W(IDX_W), .BIN_W(BIN_W)
  ) uPath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .outValid  (binValid),
    .snapIn    (phaseSnap),
    .coarseIn  (coarseIn),
    .binCode   (binCode),
    .noEdge    (noEdge),
    .coarseOut (coarseOut)
  );

  // R7: the timestamp reaches the output unchanged with its hit
  a_r7_coarse_pass: assert property (@(posedge clk) disable iff (rst)
    hitValid |-> ##2 (coarseOut == $past(coarseIn, 2)));

endmodule

// File: tb/tb_phaseEdgeEncoder.sv
module tb_phaseEdgeEncoder;
  localparam int TAPS  = 60;
  localparam int CW    = 32;
  localparam int BIN_W = $clog2(TAPS) + 1;

  logic                    clk = 1'b0;
  logic                    rst;
  logic                    hitValid;
  logic [TAPS-1:0]         phaseSnap;
  logic [CW-1:0]           coarseIn;
  logic                    binValid;
  logic signed [BIN_W-1:0] binCode;
  logic                    noEdge;
  logic [CW-1:0]           coarseOut;

  phaseEdgeEncoder #(.TAPS(TAPS), .COARSE_W(CW)) dut (
    .clk(clk), .rst(rst), .hitValid(hitValid), .phaseSnap(phaseSnap),
    .coarseIn(coarseIn), .binValid(binValid), .binCode(binCode),
    .noEdge(noEdge), .coarseOut(coarseOut)
  );

  always #2 clk = ~clk;

  int  nVec = 0;
  int  nBad = 0;
  bit  done = 0;

  // history of driven slots: index 0 newest, 1 older
  bit              hV [2];
  logic [TAPS-1:0] hS [2];
  logic [CW-1:0]   hC [2];
  string           hT [2];
  // last published result, as expected
  int              eCode = 0;
  bit              eNe   = 0;
  logic [CW-1:0]   eCo   = '0;

  task automatic check(string tag, longint got, longint exp);
    nVec++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // independent reference: linear scan for the first differing tap
  task automatic refEncode(input logic [TAPS-1:0] s, output int code, output bit ne);
    code = 0;
    ne   = 1;
    for (int i = 1; i < TAPS; i++) begin
      if (ne && (s[i] != s[i-1])) begin
        code = s[i] ? i : -i;
        ne   = 0;
      end
    end
  endtask

  task automatic cycle(bit v, logic [TAPS-1:0] s, logic [CW-1:0] c, string tag);
    int code;
    bit ne;
    @(negedge clk);
    if (hV[1]) begin
      refEncode(hS[1], code, ne);
      eCode = code; eNe = ne; eCo = hC[1];
      check("R2 valid", binValid, 1);
      check({hT[1], " code"}, int'(binCode), eCode);
    end else begin
      check("R2 idle", binValid, 0);
      check("R8 held code", int'(binCode), eCode);
    end
    check("R6 noEdge", noEdge, eNe);
    check("R7 coarse", coarseOut, eCo);
    hV[1] = hV[0]; hS[1] = hS[0]; hC[1] = hC[0]; hT[1] = hT[0];
    hV[0] = v;     hS[0] = s;     hC[0] = c;     hT[0] = tag;
    hitValid  = v;
    phaseSnap = s;
    coarseIn  = c;
  endtask

  function automatic logic [TAPS-1:0] band(int lo, int hi, bit inv);
    logic [TAPS-1:0] b = '0;
    for (int i = 0; i < TAPS; i++) if (i >= lo && i < hi) b[i] = 1'b1;
    return inv ? ~b : b;
  endfunction

  function automatic logic [TAPS-1:0] rnd();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got 0 expected 1 (run finished)");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd1357);
    for (int i = 0; i < 2; i++) begin
      hV[i] = 0; hS[i] = '0; hC[i] = '0; hT[i] = "";
    end
    rst = 1'b1; hitValid = 1'b0; phaseSnap = rnd(); coarseIn = $urandom;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid in reset", binValid, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid", binValid, 0);
    check("R1 code", int'(binCode), 0);
    check("R1 noEdge", noEdge, 0);
    check("R1 coarse", coarseOut, 0);

    // directed corners
    cycle(1, '0,  32'h11, "R6 all-zero");
    cycle(1, '1,  32'h22, "R6 all-one");
    cycle(1, band(1, TAPS, 0), 32'h33, "R10 +1");
    cycle(1, band(TAPS-1, TAPS, 0), 32'h44, "R10 +max");
    cycle(1, band(TAPS-1, TAPS, 1), 32'h55, "R10 -max");
    cycle(1, band(0, 1, 0), 32'h66, "R10 -1");
    cycle(1, band(10, 30, 0), 32'h77, "R5 two edges rising");
    cycle(1, band(7, 40, 1), 32'h88, "R4 falling then rising");
    cycle(1, band(0, 25, 0), 32'h99, "R4 falling");
    cycle(1, band(33, TAPS, 0), 32'haa, "R3 rising");
    // idle slots with garbage inputs must be ignored
    for (int k = 0; k < 4; k++) cycle(0, rnd(), $urandom, "R8 idle");
    cycle(1, band(5, 6, 0), 32'hbb, "R5 narrow pulse");
    cycle(0, rnd(), $urandom, "R8 idle");

    // constrained random, back to back
    for (int k = 0; k < 400; k++) begin
      bit v;
      int lo;
      int hi;
      logic [TAPS-1:0] s;
      v  = ($urandom % 4) != 0;
      lo = $urandom_range(0, TAPS - 1);
      hi = $urandom_range(lo, TAPS);
      if (($urandom % 8) == 0) s = rnd();
      else                     s = band(lo, hi, $urandom % 2);
      cycle(v, s, $urandom, "R9 stream");
    end
    for (int k = 0; k < 3; k++) cycle(0, '0, '0, "R8 flush");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule